// File: doc/BRIEF.md
# Reset and Clock Control Unit

This block sits at the root of a chip's clocking and reset tree. It runs entirely on the raw oscillator clock. From that clock it derives two single-cycle enable strobes: an internal clock enable, and a slower CPU clock enable. The internal strobe is either the oscillator rate or half of it. The CPU strobe is the internal strobe passed through a programmable prescaler. Downstream logic stays on the oscillator clock and qualifies its registers with these strobes, so the design never uses a gated clock.

The unit also decides what a HALT request does. With the software-reset enable cleared, HALT freezes the unit: both strobes stop and register writes are ignored until an external reset arrives. With the enable set, HALT starts a software reset instead. That reset drives the system reset output high for a fixed number of oscillator cycles and returns the configuration to its defaults.

A flag register records which source caused the most recent reset: watchdog, software or power-on. Software reads it through a small register port. The read data is combinational from the address.

Top module: `clkrst_ctrl`

## Requirements
- R1: After power-on reset the register at address 0 (mode) reads E0h, address 1 (control) reads 00h, address 2 (flags) reads 08h, and clk_stopped is 0.
- R2: Mode bit 5 selects the internal clock rate. When it is 0, int_clk_en is high every cycle. When it is 1, int_clk_en pulses every second cycle and never in two consecutive cycles.
- R3: Mode bits 4:2 hold a prescale value N. For N=0, cpu_clk_en equals int_clk_en. For N>0, cpu_clk_en pulses once per N+1 int_clk_en pulses. cpu_clk_en is never high without int_clk_en.
- R4: A new prescale value takes effect only after the CPU period in progress completes, so no CPU period is ever shortened.
- R5: Only bit 3 of the control register (software-reset enable) is writable. Its other bits always read 0.
- R6: A halt_req_i pulse while the enable is 0 sets clk_stopped in the next cycle. While clk_stopped is high, both enables stay low, register writes and further halt requests are ignored, and only a watchdog or power-on reset clears the state.
- R7: A halt_req_i pulse while the enable is 1 drives sys_rst high for exactly 16 cycles. It restores the mode and control registers to their reset values and makes the flags read 28h. A halt request during those 16 cycles is ignored.
- R8: A watchdog reset restores the mode and control registers, clears clk_stopped, and makes the flags read 48h. Flag bit 6 is the watchdog flag and bit 5 is the software flag.
- R9: Power-on reset outranks a simultaneous watchdog reset and clears both cause flags, so the flags read 08h.
- R10: Writes to the flag register change no flag bit.
- R11: sys_rst is high in every cycle in which rst_por or wdg_rst_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, the only clock |
| rst_por | input | 1 | Power-on reset, synchronous, active high |
| wdg_rst_i | input | 1 | Watchdog reset request, synchronous, active high |
| halt_req_i | input | 1 | HALT request pulse |
| reg_addr | input | 2 | Register select: 0 mode, 1 control, 2 flags |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| int_clk_en | output | 1 | Internal clock enable strobe |
| cpu_clk_en | output | 1 | CPU clock enable strobe |
| sys_rst | output | 1 | System reset output |
| clk_stopped | output | 1 | High while halted with clocks stopped |

## Verification
A prescale write can land in the same cycle as a CPU strobe, which is the division boundary. The bench waits for a CPU strobe and issues the write in that cycle. It then requires one more full period at the old ratio before the new one appears. A halt request can also arrive while a software reset is already counting, at a point where the control register has just been cleared. The bench pulses HALT in the middle of the sequence. It checks that sys_rst still lasts exactly 16 cycles and that the unit does not fall into the stopped state.

// File: rtl/clkrst_pkg.sv
package clkrst_pkg;
    localparam int DATA_W      = 8;
    localparam int ADDR_W      = 2;
    localparam int PRS_W       = 3;
    localparam int SRST_CYCLES = 16;

    localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(2);

    localparam int MODE_DIV2_BIT = 5;
    localparam int MODE_PRS_LSB  = 2;
    localparam int CTRL_SRST_BIT = 3;
    localparam int FLAG_WDG_BIT  = 6;
    localparam int FLAG_SOFT_BIT = 5;
    localparam int FLAG_ONE_BIT  = 3;

    typedef struct packed {
        logic             div2;
        logic [PRS_W-1:0] prs;
    } clk_cfg_t;

    typedef enum logic [1:0] {
        CAUSE_NONE,
        CAUSE_POR,
        CAUSE_WDG,
        CAUSE_SOFT
    } rst_cause_e;

    localparam clk_cfg_t CFG_RST = '{div2: 1'b1, prs: '0};

    function automatic logic [DATA_W-1:0] mode_byte(clk_cfg_t c);
        logic [DATA_W-1:0] r;
        r = '0;
        r[DATA_W-1 -: 2] = 2'b11;
        r[MODE_DIV2_BIT] = c.div2;
        r[MODE_PRS_LSB +: PRS_W] = c.prs;
        return r;
    endfunction

    function automatic clk_cfg_t cfg_from_byte(logic [DATA_W-1:0] b);
        clk_cfg_t c;
        c.div2 = b[MODE_DIV2_BIT];
        c.prs  = b[MODE_PRS_LSB +: PRS_W];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] flag_byte(logic wdg_f, logic soft_f);
        logic [DATA_W-1:0] r;
        r = '0;
        r[FLAG_WDG_BIT]  = wdg_f;
        r[FLAG_SOFT_BIT] = soft_f;
        r[FLAG_ONE_BIT]  = 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/clkrst_halt.sv
module clkrst_halt
    import clkrst_pkg::*;
#(
    parameter int HOLD_CYCLES = SRST_CYCLES
) (
    input  logic clk,
    input  logic rst_por,
    input  logic wdg_rst,
    input  logic halt_req,
    input  logic srst_en,
    output logic stopped,
    output logic soft_active,
    output logic soft_start
);
    localparam int CNT_W = $clog2(HOLD_CYCLES + 1);

    logic [CNT_W-1:0] hold_cnt;
    logic             stop_q;
    logic             idle;
    logic             halt_stop;

    assign idle        = !stop_q && (hold_cnt == '0);
    assign soft_start  = halt_req && idle && srst_en && !rst_por && !wdg_rst;
    assign halt_stop   = halt_req && idle && !srst_en && !rst_por && !wdg_rst;
    assign stopped     = stop_q;
    assign soft_active = (hold_cnt != '0);

    always_ff @(posedge clk) begin
        if (rst_por || wdg_rst) begin
            stop_q   <= 1'b0;
            hold_cnt <= '0;
        end else if (soft_start) begin
            hold_cnt <= CNT_W'(HOLD_CYCLES);
        end else begin
            if (halt_stop) begin
                stop_q <= 1'b1;
            end
            if (hold_cnt != '0) begin
                hold_cnt <= hold_cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/clkrst_regs.sv
module clkrst_regs
    import clkrst_pkg::*;
(
    input  logic              clk,
    input  logic              rst_por,
    input  logic              wdg_rst,
    input  logic              soft_start,
    input  logic              wr_allow,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output clk_cfg_t          cfg,
    output logic              srst_en,
    output logic              wdg_flag,
    output logic              soft_flag
);
    rst_cause_e cause;

    always_comb begin
        if (rst_por)         cause = CAUSE_POR;
        else if (wdg_rst)    cause = CAUSE_WDG;
        else if (soft_start) cause = CAUSE_SOFT;
        else                 cause = CAUSE_NONE;
    end

    always_ff @(posedge clk) begin
        if (cause != CAUSE_NONE) begin
            cfg       <= CFG_RST;
            srst_en   <= 1'b0;
            wdg_flag  <= (cause == CAUSE_WDG);
            soft_flag <= (cause == CAUSE_SOFT);
        end else if (we && wr_allow) begin
            case (addr)
                A_MODE:  cfg     <= cfg_from_byte(wdata);
                A_CTRL:  srst_en <= wdata[CTRL_SRST_BIT];
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_MODE:  rdata = mode_byte(cfg);
            A_CTRL:  rdata[CTRL_SRST_BIT] = srst_en;
            A_FLAG:  rdata = flag_byte(wdg_flag, soft_flag);
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/clkrst_div.sv
module clkrst_div
    import clkrst_pkg::*;
(
    input  logic     clk,
    input  logic     run,
    input  clk_cfg_t cfg,
    output logic     int_en,
    output logic     cpu_en
);
    logic             phase;
    logic [PRS_W-1:0] pre_cnt;
    logic [PRS_W-1:0] act_prs;
    logic             at_edge;

    assign int_en  = run && (!cfg.div2 || phase);
    assign at_edge = (pre_cnt == act_prs);
    assign cpu_en  = int_en && at_edge;

    always_ff @(posedge clk) begin
        if (!run) begin
            phase   <= 1'b0;
            pre_cnt <= '0;
            act_prs <= cfg.prs;
        end else begin
            phase <= cfg.div2 ? !phase : 1'b0;
            if (int_en) begin
                if (at_edge) begin
                    pre_cnt <= '0;
                    act_prs <= cfg.prs;
                end else begin
                    pre_cnt <= pre_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/clkrst_ctrl.sv
module clkrst_ctrl
    import clkrst_pkg::*;
#(
    parameter int HOLD_CYCLES = SRST_CYCLES
) (
    input  logic              clk,
    input  logic              rst_por,
    input  logic              wdg_rst_i,
    input  logic              halt_req_i,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              int_clk_en,
    output logic              cpu_clk_en,
    output logic              sys_rst,
    output logic              clk_stopped
);
    clk_cfg_t cfg;
    logic     srst_en;
    logic     wdg_flag;
    logic     soft_flag;
    logic     stopped;
    logic     soft_active;
    logic     soft_start;
    logic     run;

    assign run         = !stopped && !soft_active && !rst_por && !wdg_rst_i;
    assign sys_rst     = rst_por || wdg_rst_i || soft_active;
    assign clk_stopped = stopped;

    clkrst_halt #(.HOLD_CYCLES(HOLD_CYCLES)) u_halt (
        .clk         (clk),
        .rst_por     (rst_por),
        .wdg_rst     (wdg_rst_i),
        .halt_req    (halt_req_i),
        .srst_en     (srst_en),
        .stopped     (stopped),
        .soft_active (soft_active),
        .soft_start  (soft_start)
    );

    clkrst_regs u_regs (
        .clk        (clk),
        .rst_por    (rst_por),
        .wdg_rst    (wdg_rst_i),
        .soft_start (soft_start),
        .wr_allow   (!stopped && !soft_active),
        .addr       (reg_addr),
        .we         (reg_we),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .cfg        (cfg),
        .srst_en    (srst_en),
        .wdg_flag   (wdg_flag),
        .soft_flag  (soft_flag)
    );

    clkrst_div u_div (
        .clk    (clk),
        .run    (run),
        .cfg    (cfg),
        .int_en (int_clk_en),
        .cpu_en (cpu_clk_en)
    );
endmodule

// File: rtl/clkrst_chk.sv
module clkrst_chk #(
    parameter int HOLD_CYCLES = 16
) (
    input logic clk,
    input logic rst_por,
    input logic wdg_rst_i,
    input logic int_clk_en,
    input logic cpu_clk_en,
    input logic sys_rst,
    input logic clk_stopped,
    input logic div2,
    input logic wdg_flag,
    input logic soft_flag
);
    localparam int LEN_W = $clog2(HOLD_CYCLES + 2) + 1;
    localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(HOLD_CYCLES);

    logic [LEN_W-1:0] run_len;
    logic             soft_hi;

    assign soft_hi = sys_rst && !rst_por && !wdg_rst_i;

    always_ff @(posedge clk) begin
        if (rst_por)      run_len <= '0;
        else if (soft_hi) run_len <= run_len + 1'b1;
        else              run_len <= '0;
    end

    AST_CPU_IN_INT: assert property (@(posedge clk) disable iff (rst_por)
        cpu_clk_en |-> int_clk_en);                                     // R3
    AST_DIV2_GAP: assert property (@(posedge clk) disable iff (rst_por)
        (div2 && int_clk_en) |=> (!int_clk_en || !div2));               // R2
    AST_STOP_QUIET: assert property (@(posedge clk) disable iff (rst_por)
        clk_stopped |-> (!int_clk_en && !cpu_clk_en));                  // R6
    AST_STOP_STICKY: assert property (@(posedge clk) disable iff (rst_por)
        (clk_stopped && !wdg_rst_i) |=> clk_stopped);                   // R6
    AST_SOFT_MAX: assert property (@(posedge clk) disable iff (rst_por)
        run_len <= LEN_MAX);                                            // R7
    AST_SOFT_FULL: assert property (@(posedge clk) disable iff (rst_por)
        ($fell(sys_rst) && !$past(wdg_rst_i) && !$past(rst_por)) |-> (run_len == LEN_MAX)); // R7
    AST_SOFT_FLAG: assert property (@(posedge clk) disable iff (rst_por)
        ($rose(sys_rst) && !wdg_rst_i) |-> (soft_flag && !wdg_flag));   // R7
    AST_WDG_FLAG: assert property (@(posedge clk) disable iff (rst_por)
        wdg_rst_i |=> (wdg_flag && !soft_flag && !clk_stopped));        // R8
    AST_RST_OUT: assert property (@(posedge clk) disable iff (rst_por)
        wdg_rst_i |-> sys_rst);                                         // R11
endmodule

bind clkrst_ctrl clkrst_chk #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
    .clk         (clk),
    .rst_por     (rst_por),
    .wdg_rst_i   (wdg_rst_i),
    .int_clk_en  (int_clk_en),
    .cpu_clk_en  (cpu_clk_en),
    .sys_rst     (sys_rst),
    .clk_stopped (clk_stopped),
    .div2        (cfg.div2),
    .wdg_flag    (wdg_flag),
    .soft_flag   (soft_flag)
);

// File: tb/clkrst_ctrl_tb.sv
module clkrst_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_por = 1'b1;
    logic       wdg_rst_i = 1'b0;
    logic       halt_req_i = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       int_clk_en;
    logic       cpu_clk_en;
    logic       sys_rst;
    logic       clk_stopped;

    int checks = 0;
    int failures = 0;

    // {div2, prs[2:0], int_gap[4:0], cpu_gap[4:0]}
    localparam logic [13:0] VEC [8] = '{
        {1'b0, 3'd0, 5'd1, 5'd1},
        {1'b0, 3'd1, 5'd1, 5'd2},
        {1'b0, 3'd3, 5'd1, 5'd4},
        {1'b0, 3'd7, 5'd1, 5'd8},
        {1'b1, 3'd0, 5'd2, 5'd2},
        {1'b1, 3'd2, 5'd2, 5'd6},
        {1'b1, 3'd5, 5'd2, 5'd12},
        {1'b1, 3'd7, 5'd2, 5'd16}
    };

    always #10 clk = !clk;

    clkrst_ctrl u_dut (
        .clk         (clk),
        .rst_por     (rst_por),
        .wdg_rst_i   (wdg_rst_i),
        .halt_req_i  (halt_req_i),
        .reg_addr    (reg_addr),
        .reg_we      (reg_we),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .int_clk_en  (int_clk_en),
        .cpu_clk_en  (cpu_clk_en),
        .sys_rst     (sys_rst),
        .clk_stopped (clk_stopped)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_addr = a;
        reg_wdata = d;
        reg_we = 1'b1;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [1:0] a, input logic [7:0] exp);
        reg_addr = a;
        #1;
        check(req, int'(reg_rdata), int'(exp));
    endtask

    task automatic gap(input bit use_cpu, output int g);
        int lim;
        lim = 0;
        while (!(use_cpu ? cpu_clk_en : int_clk_en) && lim < 100) begin
            tick();
            lim++;
        end
        tick();
        g = 1;
        while (!(use_cpu ? cpu_clk_en : int_clk_en) && g < 100) begin
            tick();
            g++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int g;
        int n;
        int pulses;
        tick();
        check("R11 sys_rst during power-on", int'(sys_rst), 1);
        tick();
        rst_por = 1'b0;
        tick();
        // R1 reset state
        rd_check("R1 mode", 2'd0, 8'hE0);
        rd_check("R1 control", 2'd1, 8'h00);
        rd_check("R1 flags", 2'd2, 8'h08);
        check("R1 clk_stopped", int'(clk_stopped), 0);
        check("R1 sys_rst low", int'(sys_rst), 0);

        // R2 R3 table of rate settings
        for (int i = 0; i < 8; i++) begin
            wr(2'd0, {2'b11, VEC[i][13], VEC[i][12:10], 2'b00});
            repeat (40) tick();
            gap(1'b0, g);
            check($sformatf("R2 int gap vec%0d", i), g, int'(VEC[i][9:5]));
            gap(1'b1, g);
            check($sformatf("R3 cpu gap vec%0d", i), g, int'(VEC[i][4:0]));
        end

        // R4 prescale change at a boundary
        wr(2'd0, 8'h0C);
        repeat (20) tick();
        n = 0;
        while (!cpu_clk_en && n < 50) begin
            tick();
            n++;
        end
        wr(2'd0, 8'h00);
        g = 1;
        while (!cpu_clk_en && g < 50) begin
            tick();
            g++;
        end
        check("R4 old period completes", g, 4);
        tick();
        g = 1;
        while (!cpu_clk_en && g < 50) begin
            tick();
            g++;
        end
        check("R4 new period", g, 1);

        // R5 control register writable bits
        wr(2'd1, 8'hFF);
        rd_check("R5 control after FF", 2'd1, 8'h08);
        wr(2'd1, 8'h00);
        rd_check("R5 control after 00", 2'd1, 8'h00);

        // R10 flag writes
        wr(2'd2, 8'hFF);
        rd_check("R10 flags after write", 2'd2, 8'h08);

        // R7 software reset via halt
        wr(2'd1, 8'h08);
        wr(2'd0, 8'h0C);
        halt_req_i = 1'b1;
        tick();
        halt_req_i = 1'b0;
        check("R7 sys_rst asserted", int'(sys_rst), 1);
        rd_check("R7 flags", 2'd2, 8'h28);
        rd_check("R7 mode restored", 2'd0, 8'hE0);
        rd_check("R7 control restored", 2'd1, 8'h00);
        n = 0;
        while (sys_rst && n < 40) begin
            n++;
            if (n == 5) halt_req_i = 1'b1;
            tick();
            halt_req_i = 1'b0;
        end
        check("R7 sys_rst length", n, 16);
        check("R7 halt during sequence ignored", int'(clk_stopped), 0);
        rd_check("R7 flags held", 2'd2, 8'h28);

        // R6 halt with clocks stopped
        halt_req_i = 1'b1;
        tick();
        halt_req_i = 1'b0;
        check("R6 clk_stopped set", int'(clk_stopped), 1);
        pulses = 0;
        for (int k = 0; k < 10; k++) begin
            if (int_clk_en || cpu_clk_en) pulses++;
            tick();
        end
        check("R6 no enable pulses", pulses, 0);
        wr(2'd0, 8'h00);
        rd_check("R6 write ignored", 2'd0, 8'hE0);
        check("R6 still stopped", int'(clk_stopped), 1);

        // R8 R11 watchdog leaves halt
        wdg_rst_i = 1'b1;
        #1;
        check("R11 sys_rst during watchdog", int'(sys_rst), 1);
        tick();
        wdg_rst_i = 1'b0;
        check("R8 clk_stopped cleared", int'(clk_stopped), 0);
        rd_check("R8 flags", 2'd2, 8'h48);
        rd_check("R8 mode", 2'd0, 8'hE0);
        gap(1'b0, g);
        check("R8 clocks resume", g, 2);
        wr(2'd2, 8'h00);
        rd_check("R10 watchdog flag kept", 2'd2, 8'h48);

        // R9 power-on over watchdog
        wdg_rst_i = 1'b1;
        rst_por = 1'b1;
        tick();
        wdg_rst_i = 1'b0;
        rst_por = 1'b0;
        tick();
        rd_check("R9 flags", 2'd2, 8'h08);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule